// File: doc/BRIEF.md
# Pin-Driven Setpoint Counter Pair

This block keeps two independent setpoints, one for lamp brightness and one for panel contrast. Each setpoint is an unsigned code that feeds a DAC outside this block. Each section is steered by two slow digital pins: an enable level and an adjust strobe. The pin pair is decoded into four actions. The section can be off with its code held, on with its code forced to midscale, on with its code held, or on with the code lowered by one step on each adjust rising edge.

The code only moves downward. Below zero it wraps to the top code. A single strobe therefore dims by one step, and (2^W − 1) strobes brighten by one step. The lamp counter is 5 bits wide and the contrast counter is 6 bits wide. Both pins of each section pass through a two-flop synchroniser. The adjust line then passes a glitch filter. The filter drops pulses shorter than `MIN_PULSE` clock cycles and raises a sticky flag when it drops one. The block flags total shutdown when neither section is on.

Top module: `setpoint_ctl`

## Requirements
- R1: After reset the lamp code is 15 and the contrast code is 31 (midscale, 2^(W−1)−1). Both glitch flags are 0.
- R2: While a section's synchronised enable is 0 and its filtered adjust is 0, its on flag is 0 and its code does not change. The code is kept through shutdown and is still there when the section is re-enabled.
- R3: While enable is 0 and filtered adjust is 1, the section's on flag is 1 and its code is loaded with midscale.
- R4: While enable is 1 and no adjust rising edge occurs, the on flag is 1 and the code holds.
- R5: Each rising edge of the filtered adjust while enable is 1 lowers the code by exactly one.
- R6: Lowering code 0 gives the maximum code (31 or 63). After 2^W − 1 strobes the code is one above its starting value.
- R7: An adjust pulse that lasts fewer than `MIN_PULSE` synchronised cycles changes nothing. It sets that section's glitch flag to 1, and the flag stays at 1 until reset.
- R8: If enable rises while the filtered adjust is already 1, no step occurs.
- R9: `all_off` is 1 exactly when both on flags are 0.
- R10: Pins of one section never change the code, on flag or glitch flag of the other section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lamp_en | input | 1 | Lamp section enable pin (asynchronous) |
| lamp_adj | input | 1 | Lamp adjust strobe pin (asynchronous) |
| lcd_en | input | 1 | Contrast section enable pin (asynchronous) |
| lcd_adj | input | 1 | Contrast adjust strobe pin (asynchronous) |
| lamp_code | output | 5 | Lamp DAC code |
| lamp_on | output | 1 | Lamp section running |
| lcd_code | output | 6 | Contrast DAC code |
| lcd_on | output | 1 | Contrast section running |
| all_off | output | 1 | Both sections are shut down |
| lamp_glitch | output | 1 | Sticky: a short lamp adjust pulse was dropped |
| lcd_glitch | output | 1 | Sticky: a short contrast adjust pulse was dropped |

## Verification
The properties assume that the step and midscale-load events come only from the decoded pin levels after the synchroniser and filter. They also assume that the enable pin of each section never changes faster than the synchroniser can resolve. The stimulus holds every intended adjust level for 32 cycles, which is longer than the 2-cycle synchroniser plus the 25-cycle filter. Every legitimate strobe therefore reaches the counter. Deliberate short pulses are only 10 cycles wide, so they fall clearly inside the rejection window and never sit on its boundary.

// File: rtl/setpoint_pkg.sv
`timescale 1ns/1ps
package setpoint_pkg;

  // decoded action of one section, index = {enable, adjust}
  typedef enum logic [1:0] {
    ACT_OFF_HOLD = 2'b00,
    ACT_ON_MID   = 2'b01,
    ACT_ON_HOLD  = 2'b10,
    ACT_ON_ADJ   = 2'b11
  } act_e;

  // midscale code of a W-bit counter
  function automatic int unsigned mid_code(input int unsigned w);
    return (32'd1 << (w - 1)) - 32'd1;
  endfunction

  // top code of a W-bit counter
  function automatic int unsigned top_code(input int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

endpackage

// File: rtl/sync2.sv
`timescale 1ns/1ps
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/glitch_filter.sv
`timescale 1ns/1ps
module glitch_filter #(
  parameter int MIN_PULSE = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  output logic lvl,
  output logic drop
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic [CW-1:0] run;
  logic          differ;

  assign differ = (s != lvl);
  // mismatch ended before the qualifying length was reached
  assign drop   = !differ && (run != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      run <= '0;
    end else if (differ) begin
      if (run == CW'(MIN_PULSE - 1)) begin
        lvl <= s;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end else begin
      run <= '0;
    end
  end
endmodule

// File: rtl/setpoint_chan.sv
`timescale 1ns/1ps
module setpoint_chan
  import setpoint_pkg::*;
#(
  parameter int W         = 5,
  parameter int MIN_PULSE = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_pin,
  input  logic         adj_pin,
  output logic [W-1:0] code,
  output logic         sect_on,
  output logic         glitch_seen,
  output logic         step_evt,
  output logic         mid_evt
);
  localparam logic [W-1:0] MID = W'(mid_code(W));

  logic [1:0] pins_s;
  logic       en_s, adj_s, adj_f, adj_d, drop;
  act_e       act;

  sync2 #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({en_pin, adj_pin}),
    .q    (pins_s)
  );

  assign en_s  = pins_s[1];
  assign adj_s = pins_s[0];

  glitch_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .s    (adj_s),
    .lvl  (adj_f),
    .drop (drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adj_d <= 1'b0;
    else        adj_d <= adj_f;
  end

  assign act      = act_e'({en_s, adj_f});
  assign step_evt = (act == ACT_ON_ADJ) && !adj_d;
  assign mid_evt  = (act == ACT_ON_MID);
  assign sect_on  = (act != ACT_OFF_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= MID;
    end else begin
      unique case (act)
        ACT_ON_MID:   code <= MID;
        ACT_ON_ADJ:   if (!adj_d) code <= code - 1'b1;
        default:      code <= code;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    glitch_seen <= 1'b0;
    else if (drop) glitch_seen <= 1'b1;
  end
endmodule

// File: rtl/setpoint_ctl.sv
`timescale 1ns/1ps
module setpoint_ctl #(
  parameter int W_LAMP    = 5,
  parameter int W_LCD     = 6,
  parameter int MIN_PULSE = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lamp_en,
  input  logic              lamp_adj,
  input  logic              lcd_en,
  input  logic              lcd_adj,
  output logic [W_LAMP-1:0] lamp_code,
  output logic              lamp_on,
  output logic [W_LCD-1:0]  lcd_code,
  output logic              lcd_on,
  output logic              all_off,
  output logic              lamp_glitch,
  output logic              lcd_glitch
);
  // event wires kept visible for the bound checker
  logic lamp_step, lamp_mid, lcd_step, lcd_mid;

  setpoint_chan #(.W(W_LAMP), .MIN_PULSE(MIN_PULSE)) u_lamp (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_pin     (lamp_en),
    .adj_pin    (lamp_adj),
    .code       (lamp_code),
    .sect_on    (lamp_on),
    .glitch_seen(lamp_glitch),
    .step_evt   (lamp_step),
    .mid_evt    (lamp_mid)
  );

  setpoint_chan #(.W(W_LCD), .MIN_PULSE(MIN_PULSE)) u_lcd (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_pin     (lcd_en),
    .adj_pin    (lcd_adj),
    .code       (lcd_code),
    .sect_on    (lcd_on),
    .glitch_seen(lcd_glitch),
    .step_evt   (lcd_step),
    .mid_evt    (lcd_mid)
  );

  assign all_off = !lamp_on && !lcd_on;
endmodule

// File: rtl/setpoint_chk.sv
`timescale 1ns/1ps
module setpoint_chk
  import setpoint_pkg::*;
#(
  parameter int WA = 5,
  parameter int WB = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [WA-1:0] lamp_code,
  input logic          lamp_on,
  input logic          lamp_step,
  input logic          lamp_mid,
  input logic [WB-1:0] lcd_code,
  input logic          lcd_on,
  input logic          lcd_step,
  input logic          lcd_mid,
  input logic          all_off
);
  localparam logic [WA-1:0] MID_A = WA'(mid_code(WA));
  localparam logic [WB-1:0] MID_B = WB'(mid_code(WB));
  localparam logic [WA-1:0] TOP_A = WA'(top_code(WA));
  localparam logic [WB-1:0] TOP_B = WB'(top_code(WB));

  a_r1_reset_mid: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (lamp_code == MID_A && lcd_code == MID_B)));

  a_r2_off_holds_lamp: assert property (@(posedge clk) disable iff (!rst_n)
    !lamp_on |=> $stable(lamp_code));
  a_r2_off_holds_lcd: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |=> $stable(lcd_code));

  a_r3_mid_load_lamp: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_mid |=> lamp_code == MID_A);
  a_r3_mid_load_lcd: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_mid |=> lcd_code == MID_B);

  a_r4_quiet_hold_lamp: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp_step && !lamp_mid) |=> $stable(lamp_code));
  a_r4_quiet_hold_lcd: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_step && !lcd_mid) |=> $stable(lcd_code));

  a_r5_step_lamp: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_step |=> lamp_code == WA'($past(lamp_code) - 1'b1));
  a_r5_step_lcd: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_step |=> lcd_code == WB'($past(lcd_code) - 1'b1));

  a_r6_wrap_lamp: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_step && lamp_code == '0) |=> lamp_code == TOP_A);
  a_r6_wrap_lcd: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_step && lcd_code == '0) |=> lcd_code == TOP_B);

  a_r9_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_on || lcd_on) |-> !all_off);

  a_r3_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lamp_step && lamp_mid) && !(lcd_step && lcd_mid));
endmodule

bind setpoint_ctl setpoint_chk #(.WA(W_LAMP), .WB(W_LCD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lamp_code(lamp_code),
  .lamp_on  (lamp_on),
  .lamp_step(lamp_step),
  .lamp_mid (lamp_mid),
  .lcd_code (lcd_code),
  .lcd_on   (lcd_on),
  .lcd_step (lcd_step),
  .lcd_mid  (lcd_mid),
  .all_off  (all_off)
);

// File: tb/setpoint_ctl_tb.sv
`timescale 1ns/1ps
module setpoint_ctl_tb;
  localparam int WA = 5;
  localparam int WB = 6;
  localparam int HOLD = 32;   // legitimate level width, cycles
  localparam int SHORT = 10;  // deliberate glitch width, cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lamp_en = 1'b0, lamp_adj = 1'b0, lcd_en = 1'b0, lcd_adj = 1'b0;
  logic [WA-1:0] lamp_code;
  logic [WB-1:0] lcd_code;
  logic lamp_on, lcd_on, all_off, lamp_glitch, lcd_glitch;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int exp_a, exp_b;

  always #2 clk = ~clk;

  setpoint_ctl u_dut (
    .clk(clk), .rst_n(rst_n),
    .lamp_en(lamp_en), .lamp_adj(lamp_adj),
    .lcd_en(lcd_en), .lcd_adj(lcd_adj),
    .lamp_code(lamp_code), .lamp_on(lamp_on),
    .lcd_code(lcd_code), .lcd_on(lcd_on),
    .all_off(all_off),
    .lamp_glitch(lamp_glitch), .lcd_glitch(lcd_glitch)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ch 0 = lamp, 1 = contrast
  task automatic strobe(input int ch, input int hi, input int lo);
    @(negedge clk);
    if (ch == 0) lamp_adj = 1'b1; else lcd_adj = 1'b1;
    wait_cyc(hi);
    if (ch == 0) lamp_adj = 1'b0; else lcd_adj = 1'b0;
    wait_cyc(lo);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    // R1 reset state
    chk(lamp_code == 15, "R1 lamp midscale", lamp_code, 15);
    chk(lcd_code == 31, "R1 lcd midscale", lcd_code, 31);
    chk(!lamp_glitch && !lcd_glitch, "R1 glitch flags clear", lamp_glitch + lcd_glitch, 0);
    chk(!lamp_on && !lcd_on, "R2 sections off at idle", lamp_on + lcd_on, 0);
    chk(all_off, "R9 all_off with both off", all_off, 1);

    // R4 enable lamp only
    lamp_en = 1'b1;
    wait_cyc(HOLD);
    chk(lamp_on, "R4 lamp on", lamp_on, 1);
    chk(lamp_code == 15, "R4 lamp holds", lamp_code, 15);
    chk(!all_off, "R9 all_off low with one on", all_off, 0);
    chk(!lcd_on, "R10 lcd stays off", lcd_on, 0);

    // R5/R6 full lamp sweep, then one-up by 2^W-1 strobes
    exp_a = 15;
    for (int i = 0; i < (1 << WA); i++) begin
      strobe(0, HOLD, HOLD);
      exp_a = (exp_a + (1 << WA) - 1) % (1 << WA);
      chk(lamp_code == exp_a, (exp_a == 31) ? "R6 lamp wrap" : "R5 lamp step", lamp_code, exp_a);
    end
    for (int i = 0; i < (1 << WA) - 1; i++) begin
      strobe(0, HOLD, HOLD);
      exp_a = (exp_a + (1 << WA) - 1) % (1 << WA);
    end
    chk(lamp_code == 16, "R6 lamp up one step", lamp_code, 16);

    // contrast sweep, lamp untouched
    lcd_en = 1'b1;
    wait_cyc(HOLD);
    exp_b = 31;
    for (int i = 0; i < (1 << WB); i++) begin
      strobe(1, HOLD, HOLD);
      exp_b = (exp_b + (1 << WB) - 1) % (1 << WB);
      chk(lcd_code == exp_b, (exp_b == 63) ? "R6 lcd wrap" : "R5 lcd step", lcd_code, exp_b);
    end
    chk(lamp_code == 16, "R10 lamp unaffected by lcd", lamp_code, 16);

    // R2 shutdown keeps codes
    lamp_en = 1'b0;
    wait_cyc(HOLD);
    chk(!lamp_on, "R2 lamp off", lamp_on, 0);
    chk(lamp_code == 16, "R2 lamp code kept", lamp_code, 16);
    chk(!all_off, "R9 one section still on", all_off, 0);
    lcd_en = 1'b0;
    wait_cyc(HOLD);
    chk(all_off, "R9 both off", all_off, 1);
    chk(lcd_code == 31, "R2 lcd code kept", lcd_code, 31);
    lamp_en = 1'b1;
    wait_cyc(HOLD);
    chk(lamp_code == 16, "R2 lamp code after re-enable", lamp_code, 16);

    // R7 short pulse ignored, sticky flag
    strobe(0, SHORT, HOLD);
    chk(lamp_code == 16, "R7 short pulse ignored", lamp_code, 16);
    chk(lamp_glitch, "R7 lamp glitch flag set", lamp_glitch, 1);
    chk(!lcd_glitch, "R10 lcd glitch flag clear", lcd_glitch, 0);
    strobe(0, HOLD, HOLD);
    chk(lamp_code == 15, "R5 step after glitch", lamp_code, 15);
    chk(lamp_glitch, "R7 glitch flag sticky", lamp_glitch, 1);

    // R3 midscale load with enable low, R8 enable rising with adjust high
    lcd_en = 1'b1;
    wait_cyc(HOLD);
    strobe(1, HOLD, HOLD);
    chk(lcd_code == 30, "R5 lcd step before load", lcd_code, 30);
    lcd_en = 1'b0;
    wait_cyc(HOLD);
    lcd_adj = 1'b1;
    wait_cyc(HOLD);
    chk(lcd_on, "R3 lcd on during load", lcd_on, 1);
    chk(lcd_code == 31, "R3 lcd midscale load", lcd_code, 31);
    lcd_en = 1'b1;
    wait_cyc(HOLD);
    chk(lcd_code == 31, "R8 no step on enable rise", lcd_code, 31);
    lcd_adj = 1'b0;
    wait_cyc(HOLD);
    chk(lcd_code == 31 && lcd_on, "R4 lcd holds after load", lcd_code, 31);
    chk(lamp_code == 15, "R10 lamp unaffected by load", lamp_code, 15);

    // R1 second reset clears sticky flag and reloads midscale
    lamp_en = 1'b0;
    lcd_en = 1'b0;
    strobe(0, HOLD, HOLD);
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    chk(!lamp_glitch, "R1 glitch flag cleared by reset", lamp_glitch, 0);
    chk(lamp_code == 15 && lcd_code == 31, "R1 midscale after reset", lamp_code, 15);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule